// File: doc/BRIEF.md
# GPIO Input Conditioner

This block cleans up a vector of asynchronous pad inputs before the rest of the chip reads them. An elaboration-time switch decides whether every bit first goes through a two-stage flip-flop synchronizer. The switch is on by default. With the switch off, the inputs are taken as already synchronous and pass straight on.

After that stage, each bit has its own debounce filter, which can be bypassed at run time through a per-bit enable. When the filter is used, the output bit moves to a new level only after the synchronized input has shown that level on 16 consecutive clock edges. Anything shorter is treated as a glitch and dropped. The resulting vector is the input-data value that software and interrupt logic read.

The filter keeps tracking even for bits whose enable is off. Turning a bit's enable on therefore shows an already settled value at once.

Top module: `gpio_in_cond`

## Requirements
- R1: With `SYNC_EN`=1, an unfiltered bit reaches `data_o` two clock edges after the pad is sampled. A pad change set up before edge e0 is visible after edge e1.
- R2: With `SYNC_EN`=0, an unfiltered bit of `data_o` equals `pad_i` in the same cycle, with no register in the path.
- R3: With the filter on, a bit takes a new level once the synchronized input has held that level on `STABLE_CYCLES` (16) consecutive edges. With `SYNC_EN`=0, a pad change set up before edge e0 is visible after edge e15. With `SYNC_EN`=1 it is visible after edge e17.
- R4: With the filter on, a level that lasts fewer than 16 edges, for example 15, never appears on `data_o`.
- R5: `filt_en_i[i]`=1 selects the filtered value for bit i, and 0 selects the synchronized value. Each bit is selected independently of the others.
- R6: A synchronous active-high `rst_i` clears the synchronizer flops, the stability counters and the filtered values to 0.
- R7: The filter runs whatever its enable is. Switching a bit's enable from 0 to 1, after its input has been stable for at least 16 edges, shows the stable level on `data_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pad_i | input | WIDTH | Raw pad inputs, asynchronous when SYNC_EN=1 |
| filt_en_i | input | WIDTH | Per-bit filter enable, 1 = filtered |
| data_o | output | WIDTH | Conditioned input data value |

## Verification
A bit's input can change in the same cycle in which its filter enable changes. A bit can also be glitching while its own counter is about to reach the threshold. The random phases provoke both. They flip pad bits and enable bits independently of each other, and they switch between glitch-heavy stretches and quiet stretches, so that runs end exactly at, just short of, and just past 16 edges. Each cycle is judged against a bench model that keeps a run length and a two-stage delay line per bit. Two instances, one with the synchronizer and one without, are checked side by side.

// File: rtl/gpio_in_cond_pkg.sv
package gpio_in_cond_pkg;
  localparam int unsigned DEF_WIDTH  = 32;
  localparam int unsigned DEF_STABLE = 16;

  function automatic int unsigned cnt_bits(input int unsigned limit);
    int unsigned w;
    w = $clog2(limit);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH   = 32,
  parameter bit          SYNC_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] sync_o
);
  if (SYNC_EN) begin : g_sync
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [1:0]       warm_q;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        stage1_q <= '0;
        stage2_q <= '0;
      end else begin
        stage1_q <= pad_i;
        stage2_q <= stage1_q;
      end
    end

    always_ff @(posedge clk_i) begin
      if (rst_i)              warm_q <= 2'd0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assign sync_o = stage2_q;

    // R1
    sync_delay_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (warm_q == 2'd2) |-> (sync_o == $past(pad_i, 2)));
  end else begin : g_pass
    assign sync_o = pad_i;
  end
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter
  import gpio_in_cond_pkg::*;
#(
  parameter int unsigned WIDTH         = 32,
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] filt_o
);
  localparam int unsigned CNT_W = cnt_bits(STABLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STABLE_CYCLES - 1);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] filt_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [CNT_W-1:0] cnt_q;
    logic             same;

    assign same = (sync_i[i] == prev_q[i]);

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        prev_q[i] <= 1'b0;
        cnt_q     <= '0;
        filt_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= sync_i[i];
        if (!same) begin
          cnt_q <= CNT_W'(1);
        end else if (cnt_q != CNT_TOP) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
        if (same && (cnt_q == CNT_TOP)) begin
          filt_q[i] <= sync_i[i];
        end
      end
    end

    // R3
    cnt_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sync_i[i] != prev_q[i]) |=> (cnt_q == CNT_W'(1)));

    // R4
    glitch_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !((sync_i[i] == prev_q[i]) && (cnt_q == CNT_TOP)) |=> $stable(filt_q[i]));

    // R6
    cnt_reset_chk: assert property (@(posedge clk_i)
      rst_i |=> (cnt_q == '0));
  end

  assign filt_o = filt_q;

  // R6
  filt_reset_chk: assert property (@(posedge clk_i)
    rst_i |=> (filt_o == '0));
endmodule

// File: rtl/gpio_in_cond.sv
module gpio_in_cond
  import gpio_in_cond_pkg::*;
#(
  parameter int unsigned WIDTH         = DEF_WIDTH,
  parameter int unsigned STABLE_CYCLES = DEF_STABLE,
  parameter bit          SYNC_EN       = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] pad_i,
  input  logic [WIDTH-1:0] filt_en_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] sync_s;
  logic [WIDTH-1:0] filt_s;

  gpio_in_sync #(
    .WIDTH  (WIDTH),
    .SYNC_EN(SYNC_EN)
  ) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .pad_i (pad_i),
    .sync_o(sync_s)
  );

  gpio_in_filter #(
    .WIDTH        (WIDTH),
    .STABLE_CYCLES(STABLE_CYCLES)
  ) u_filter (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .sync_i(sync_s),
    .filt_o(filt_s)
  );

  assign data_o = (filt_en_i & filt_s) | (~filt_en_i & sync_s);

  // R5
  always_comb begin
    for (int i = 0; i < int'(WIDTH); i++) begin
      if (filt_en_i[i] && (sync_s[i] == filt_s[i])) begin
        bypass_agree_chk: assert (data_o[i] == sync_s[i]);
      end
    end
  end
endmodule

// File: tb/gpio_in_cond_tb.sv
module gpio_in_cond_tb;
  localparam int W  = 32;
  localparam int ST = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pad = '0;
  logic [W-1:0] en  = '0;
  logic [W-1:0] out_s;
  logic [W-1:0] out_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  gpio_in_cond #(.WIDTH(W), .STABLE_CYCLES(ST), .SYNC_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_i(rst), .pad_i(pad), .filt_en_i(en), .data_o(out_s));

  gpio_in_cond #(.WIDTH(W), .STABLE_CYCLES(ST), .SYNC_EN(1'b0)) u_dut_nosync (
    .clk_i(clk), .rst_i(rst), .pad_i(pad), .filt_en_i(en), .data_o(out_n));

  // Reference model: delay line plus per-bit run length
  logic [W-1:0] m1, m2;
  logic [W-1:0] prv  [2];
  logic [W-1:0] fexp [2];
  int           run  [2][W];

  always @(posedge clk) begin
    logic [W-1:0] s_now;
    if (rst) begin
      m1 = '0; m2 = '0;
      for (int k = 0; k < 2; k++) begin
        prv[k] = '0; fexp[k] = '0;
        for (int b = 0; b < W; b++) run[k][b] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        s_now = (k == 0) ? m2 : pad;
        for (int b = 0; b < W; b++) begin
          if (s_now[b] == prv[k][b]) begin
            if (run[k][b] < 1000) run[k][b]++;
          end else begin
            run[k][b] = 1;
          end
          if (run[k][b] >= ST) fexp[k][b] = s_now[b];
        end
        prv[k] = s_now;
      end
      m2 = m1;
      m1 = pad;
    end
  end

  function automatic logic [W-1:0] pick(input logic [W-1:0] e,
                                        input logic [W-1:0] f,
                                        input logic [W-1:0] s);
    return (e & f) | (~e & s);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // advance one cycle, compare both instances against the model
  task automatic step();
    @(negedge clk);
    check("R1 R3 R5 sync", out_s, pick(en, fexp[0], m2));
    check("R2 R3 R5 nosync", out_n, pick(en, fexp[1], pad));
  endtask

  task automatic hold(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] flip;
    logic [W-1:0] sv_en;
    void'($urandom(32'd1234));

    // R6: reset with pads high, all filtered, then all bypassed
    pad = '1;
    en  = '1;
    repeat (3) @(negedge clk);
    check("R6 reset filtered sync", out_s, '0);
    check("R6 reset filtered nosync", out_n, '0);
    en = '0;
    #1;
    check("R6 reset bypass sync", out_s, '0);
    @(negedge clk);
    rst = 1'b0;
    pad = '0;
    en  = '1;
    hold(20);

    // R3: one hold of exactly 16 edges, sampled on both sides of the update
    pad[0] = 1'b1;
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      if (k == 15) check("R3 nosync before window", out_n[0], 1'b0);
      if (k == 16) check("R3 nosync at window", out_n[0], 1'b1);
      if (k == 17) check("R3 sync before window", out_s[0], 1'b0);
      if (k == 18) check("R3 sync at window", out_s[0], 1'b1);
    end

    // R4: a 15-edge pulse must not pass
    pad[1] = 1'b1;
    hold(15);
    pad[1] = 1'b0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (out_s[1] !== 1'b0 || out_n[1] !== 1'b0) begin
        check("R4 short pulse leaked", {out_s[1], out_n[1]}, 2'b00);
      end
    end
    check("R4 short pulse sync", out_s[1], 1'b0);
    check("R4 short pulse nosync", out_n[1], 1'b0);

    // R1/R2: bypassed bit 2 timing
    en[2]  = 1'b0;
    pad[2] = 1'b1;
    #1;
    check("R2 nosync passthrough", out_n[2], 1'b1);
    @(negedge clk);
    check("R1 sync after one edge", out_s[2], 1'b0);
    @(negedge clk);
    check("R1 sync after two edges", out_s[2], 1'b1);

    // R5: neighbouring bits with different enables
    pad[4:3] = 2'b11;
    en[4:3]  = 2'b01;
    hold(3);
    check("R5 bypassed bit 4", out_s[4], 1'b1);
    check("R5 filtered bit 3", out_s[3], 1'b0);

    // R7: settle while bypassed, then enable
    en[5]  = 1'b0;
    pad[5] = 1'b1;
    hold(20);
    en[5] = 1'b1;
    #1;
    check("R7 settled sync", out_s[5], 1'b1);
    check("R7 settled nosync", out_n[5], 1'b1);

    // random phases: glitchy and quiet stretches, enable flips
    for (int ph = 0; ph < 40; ph++) begin
      for (int c = 0; c < 200; c++) begin
        flip = '0;
        for (int b = 0; b < W; b++) begin
          if (ph % 2 == 0) flip[b] = ($urandom % 8) == 0;
          else             flip[b] = ($urandom % 64) == 0;
        end
        pad = pad ^ flip;
        if (($urandom % 16) == 0) en = en ^ (W'(1) << ($urandom % W));
        step();
      end
    end

    // R7 on a random vector: bypass, settle, enable all at once
    sv_en = en;
    en  = '0;
    pad = $urandom;
    hold(ST + 3);
    en = '1;
    #1;
    check("R7 all bits sync", out_s, pad);
    check("R7 all bits nosync", out_n, pad);
    en = sv_en;
    hold(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule